// File: doc/BRIEF.md
# Baud Tick Generator

This block derives a serial-clock timing strobe from the module clock. The divide factor is the product of two settings carried in one 16-bit clock-select word. The first is a 5-bit prescale value, stored as the count minus one, so it covers 1 to 32. The second is a 3-bit code that selects a power-of-two post-divider or a bypass. The output `half_tick_o` pulses for one module-clock cycle once every N cycles, where N is the total divide factor. The serial engine toggles its shift clock on every pulse, so the pulse rate is twice the bit rate and the engine can act on both edges of the serial clock. One instance serves the transmit side and a separate instance serves the receive side.

The generator runs only while `run_i` is high. While `run_i` is low, both counters are held at zero and the clock-select word is sampled on every cycle. While `run_i` is high, the sampled settings are frozen. This keeps a register write from bending a period that is already in progress. It also makes the timing after each enable deterministic.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale field sits in `clk_sel_i[12:8]` and holds P-1. With divider code 7, the pulse period is P module-clock cycles, for P from 1 to 32.
- R2: Divider codes 0, 1, 2, 3 and 4 in `clk_sel_i[2:0]` multiply the period by 2, 4, 8, 16 and 32 respectively.
- R3: Divider code 7 bypasses the post-divider, which gives a factor of 1.
- R4: The reserved divider codes 5 and 6 behave exactly like code 7.
- R5: The largest setting is prescale field 31 with code 4. It gives a period of 1024 cycles.
- R6: `half_tick_o` is low in every cycle in which `run_i` is low.
- R7: Count the cycles from the first one in which `run_i` is high, starting at 1. The first pulse appears in cycle N, and further pulses follow exactly every N cycles.
- R8: Dropping `run_i` for a single cycle part-way through a period discards the partial count. The next pulse after re-enabling again comes N cycles later.
- R9: Changes to `clk_sel_i` while `run_i` is high have no effect on the period. A new value takes effect only after `run_i` has been low for at least one clock edge.
- R10: Bits 15:13 and 7:3 of `clk_sel_i` have no effect on the period.
- R11: During and after a synchronous reset (`rst_ni` low), `half_tick_o` is low until the generator is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Generator enable; low clears the counters and samples the settings |
| clk_sel_i | input | 16 | Clock-select word: prescale in 12:8, divider code in 2:0 |
| half_tick_o | output | 1 | One-cycle pulse, twice per serial bit period |

## Verification
The bench builds the block with its default parameters: a 5-bit prescale field, a 3-bit divider code and five power-of-two stages. With these values every code, including the reserved ones, can be reached, and so can the full 1-to-1024 divide range. The longest period still fits easily in a short run. The vector table covers the bypass edge with N=1, where a pulse occurs on every cycle, as well as the maximum setting and mixed prescale and divider products. Directed cases then test restart after a one-cycle disable, a settings write while running, and the effect of the unused select bits.

// File: rtl/baud_gen_pkg.sv
// Package: shared widths, the settings record and the divider-code decode
// for the baud tick generator. Assumes the code values 0..4 are the only
// ones that select a divider; every other code means no divider stage.
package baud_gen_pkg;

    parameter int PRE_W     = 5;  // prescale field width
    parameter int CODE_W    = 3;  // divider code width
    parameter int MAX_SHIFT = 5;  // largest power-of-two divider exponent
    parameter int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;   // prescale count minus one
        logic [CODE_W-1:0] code;  // divider code
    } bg_cfg_t;

    // Decode a divider code into the exponent of its power-of-two ratio.
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        logic [SHIFT_W-1:0] sh;
        if (int'(code) < MAX_SHIFT)
            sh = SHIFT_W'(int'(code) + 1);
        else
            sh = '0;
        return sh;
    endfunction

endpackage

// File: rtl/bg_cfg_hold.sv
// Settings holder: extracts the prescale and divider-code fields from the
// select word and tracks them only while the generator is stopped, so a
// running period never sees a half-written setting.
// Assumes the field positions given by the parameters fit in SEL_W.
module bg_cfg_hold
    import baud_gen_pkg::*;
#(
    parameter int SEL_W    = 16,
    parameter int PRE_LSB  = 8,
    parameter int CODE_LSB = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output bg_cfg_t          cfg_o
);

    bg_cfg_t cfg_q;

    // Sample the fields every cycle the generator is idle; freeze while running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (!run_i) begin
            cfg_q.pre  <= sel_i[PRE_LSB +: PRE_W];
            cfg_q.code <= sel_i[CODE_LSB +: CODE_W];
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/bg_prescaler.sv
// Prescaler: counts module clocks from zero up to the stored limit (value
// minus one) and flags the last cycle of each prescale period.
// Assumes the limit is stable while run_i is high.
module bg_prescaler
    import baud_gen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PRE_W-1:0] limit_i,
    output logic [PRE_W-1:0] cnt_o,
    output logic             carry_o
);

    logic [PRE_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == limit_i);

    // Advance the count, wrap at the limit, hold at zero when stopped.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i)
            cnt_q <= '0;
        else if (at_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PRE_W'(1);
    end

    assign carry_o = run_i && at_end;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/bg_binary_div.sv
// Post-divider: a chain of toggle stages advanced by the prescaler carry.
// The decoded shift masks the chain so that only the low 'shift' stages
// must all be one for a carry to become a tick; shift 0 passes every carry.
// Assumes shift_i is stable while run_i is high.
module bg_binary_div
    import baud_gen_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               carry_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [MAX_SHIFT-1:0] cnt_o,
    output logic               tick_o
);

    logic [MAX_SHIFT-1:0] stage_q;
    logic [MAX_SHIFT:0]   lower_ones;
    logic [MAX_SHIFT-1:0] used_mask;

    assign lower_ones[0] = 1'b1;

    for (genvar k = 0; k < MAX_SHIFT; k++) begin : g_stage
        assign lower_ones[k+1] = lower_ones[k] & stage_q[k];
        assign used_mask[k]    = (int'(shift_i) > k);

        // Toggle this stage when every stage below it is one at a carry.
        always_ff @(posedge clk_i) begin
            if (!rst_ni || !run_i)
                stage_q[k] <= 1'b0;
            else if (carry_i && lower_ones[k])
                stage_q[k] <= ~stage_q[k];
        end
    end

    assign tick_o = carry_i && (&(stage_q | ~used_mask));
    assign cnt_o  = stage_q;

endmodule

// File: rtl/baud_tick_gen.sv
// Baud tick generator top: a settings holder, a prescaler and a binary
// post-divider in series. The output pulses once every
// (prescale+1) * 2^shift module clocks while run_i is high. The first pulse
// falls on the last cycle of the first full period after enabling.
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter int SEL_W    = 16,
    parameter int PRE_LSB  = 8,
    parameter int CODE_LSB = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    output logic             half_tick_o
);

    bg_cfg_t              cfg;
    logic [PRE_W-1:0]     cfg_pre;
    logic [CODE_W-1:0]    cfg_code;
    logic [SHIFT_W-1:0]   shift;
    logic [PRE_W-1:0]     pre_cnt;
    logic [MAX_SHIFT-1:0] div_cnt;
    logic                 pre_carry;

    assign cfg_pre  = cfg.pre;
    assign cfg_code = cfg.code;
    assign shift    = code_to_shift(cfg_code);

    bg_cfg_hold #(
        .SEL_W    (SEL_W),
        .PRE_LSB  (PRE_LSB),
        .CODE_LSB (CODE_LSB)
    ) u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .sel_i  (clk_sel_i),
        .cfg_o  (cfg)
    );

    bg_prescaler u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .limit_i (cfg_pre),
        .cnt_o   (pre_cnt),
        .carry_o (pre_carry)
    );

    bg_binary_div u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .carry_i (pre_carry),
        .shift_i (shift),
        .cnt_o   (div_cnt),
        .tick_o  (half_tick_o)
    );

endmodule

// File: rtl/bg_checker.sv
// Checker for the baud tick generator: measures the gap between pulses with
// its own counter and relates it to the frozen settings, and watches the
// stop/hold behaviour of the counters and settings.
module bg_checker
    import baud_gen_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 run_i,
    input logic                 tick_i,
    input logic [PRE_W-1:0]     cfg_pre_i,
    input logic [CODE_W-1:0]    cfg_code_i,
    input logic [PRE_W-1:0]     pre_cnt_i,
    input logic [MAX_SHIFT-1:0] div_cnt_i
);

    localparam int GAP_W = PRE_W + MAX_SHIFT + 1;

    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] exp_n;

    assign exp_n = (GAP_W'(cfg_pre_i) + GAP_W'(1)) << code_to_shift(cfg_code_i);

    // Cycles elapsed since enable or since the last pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i || tick_i)
            gap_q <= '0;
        else
            gap_q <= gap_q + GAP_W'(1);
    end

    // R6
    quiet_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !tick_i);

    // R7
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i) |-> (gap_q + GAP_W'(1) == exp_n));

    // R8
    counters_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (pre_cnt_i == '0 && div_cnt_i == '0));

    // R9
    settings_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i)) |-> ($stable(cfg_pre_i) && $stable(cfg_code_i)));

    // R1
    prescale_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_cnt_i <= cfg_pre_i);

endmodule

bind baud_tick_gen bg_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .tick_i     (half_tick_o),
    .cfg_pre_i  (cfg_pre),
    .cfg_code_i (cfg_code),
    .pre_cnt_i  (pre_cnt),
    .div_cnt_i  (div_cnt)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] sel = '0;
    logic        tick;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    baud_tick_gen u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .run_i       (run),
        .clk_sel_i   (sel),
        .half_tick_o (tick)
    );

    typedef struct packed {
        logic [15:0] sel;
        logic [15:0] n;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{16'h0007, 16'd1,    4'd3},
        '{16'h0107, 16'd2,    4'd1},
        '{16'h1F07, 16'd32,   4'd1},
        '{16'h0000, 16'd2,    4'd2},
        '{16'h0001, 16'd4,    4'd2},
        '{16'h0002, 16'd8,    4'd2},
        '{16'h0003, 16'd16,   4'd2},
        '{16'h0004, 16'd32,   4'd2},
        '{16'h0005, 16'd1,    4'd4},
        '{16'h0006, 16'd1,    4'd4},
        '{16'h0406, 16'd5,    4'd4},
        '{16'h0203, 16'd48,   4'd2},
        '{16'h1F04, 16'd1024, 4'd5}
    };

    function automatic string tag(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Stop, load a setting, idle, then enable. Reports the cycle number
    // (first enabled cycle = 1) of the first two pulses.
    task automatic measure(input logic [15:0] s, output int t1, output int t2);
        int c = 0;
        int got = 0;
        @(negedge clk);
        run = 1'b0;
        sel = s;
        repeat (3) @(negedge clk);
        run = 1'b1;
        t1 = 0;
        t2 = 0;
        while (got < 2 && c < 5000) begin
            c++;
            #1;
            if (tick) begin
                if (got == 0) t1 = c; else t2 = c;
                got++;
            end
            @(negedge clk);
        end
        run = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t1, t2, c, hits;
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R11", "tick in reset", int'(tick), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R11", "tick after reset", int'(tick), 0);

        // R1..R5, R7: table walk
        for (int i = 0; i < NV; i++) begin
            measure(VEC[i].sel, t1, t2);
            check(tag(int'(VEC[i].req)), $sformatf("first tick sel=%h", VEC[i].sel), t1, int'(VEC[i].n));
            check("R7", $sformatf("tick spacing sel=%h", VEC[i].sel), t2 - t1, int'(VEC[i].n));
        end

        // R6: no pulses while stopped, even with the fastest setting
        @(negedge clk);
        run = 1'b0;
        sel = 16'h0007;
        hits = 0;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (tick) hits++;
            @(negedge clk);
        end
        check("R6", "ticks while stopped", hits, 0);

        // R8: restart after a one-cycle stop mid-period (N=8)
        @(negedge clk);
        sel = 16'h0300;
        repeat (3) @(negedge clk);
        run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        c = 0;
        t1 = 0;
        while (t1 == 0 && c < 100) begin
            c++;
            #1;
            if (tick) t1 = c;
            @(negedge clk);
        end
        check("R8", "first tick after restart", t1, 8);
        run = 1'b0;

        // R9: write while running is ignored (N=4 kept), applied after stop (N=32)
        @(negedge clk);
        sel = 16'h0100;
        repeat (3) @(negedge clk);
        run = 1'b1;
        c = 0;
        t1 = 0;
        t2 = 0;
        hits = 0;
        while (hits < 2 && c < 500) begin
            c++;
            #1;
            if (tick) begin
                if (hits == 0) begin
                    t1 = c;
                    sel = 16'h1F07;
                end else begin
                    t2 = c;
                end
                hits++;
            end
            @(negedge clk);
        end
        check("R9", "spacing after write while running", t2 - t1, 4);
        run = 1'b0;
        measure(16'h1F07, t1, t2);
        check("R9", "new setting after stop", t1, 32);

        // R10: unused select bits set have no effect (pre=2, code 1 -> 12)
        measure(16'hE2F9, t1, t2);
        check("R10", "first tick with junk bits", t1, 12);
        check("R10", "spacing with junk bits", t2 - t1, 12);

        // R11: reset mid-run clears and silences
        @(negedge clk);
        sel = 16'h0007;
        run = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        @(negedge clk);
        #1;
        check("R11", "tick after mid-run reset", int'(tick), 0);
        rst_n = 1'b1;

        summary();
        $finish;
    end

endmodule